// File: doc/BRIEF.md
# Bitmask Merge Write Pipeline

This block collects a stream of set events, each naming a row and carrying an 8-bit mask, and accumulates them into an internal row store whose reads take three cycles. At most one event arrives per cycle. Every event goes through a three-stage read-modify-write pipeline. When it reaches the oldest stage, the stored row is rewritten as the old contents OR all the masks that were merged into that entry. Bits are never cleared, so each row ends up as the OR of every mask ever sent to it.

Two writes to the same row can overlap in the pipeline. To keep both, each new event is compared against the enabled entries still in flight, and the result is one of four merge choices:

- **MRG_NONE**: no enabled entry holds the row, so the event opens a new enabled entry in the newest stage.
- **MRG_NEWEST**: the newest stage holds the row. Its mask, OR the new mask, moves into the middle stage, and the newest stage is loaded empty and disabled.
- **MRG_MIDDLE**: the middle stage holds the row. Its mask, OR the new mask, moves into the oldest stage, and the newest stage is loaded empty and disabled.
- **Commit fold**: the oldest stage holds the row and is writing it in this very cycle. The value being written is ORed into the new event's read path, so the new entry's read-modify-write sees it.

The newest stage has priority over the middle one. Stages that are disabled never match.

The commit side is visible on a write port: valid, row and data, taken from the oldest stage. A combinational peek port returns the stored value of any row.

Top module: `mask_merge_pipe`

## Requirements
- R1: After reset, no commit is reported during the first three cycles, and every row of the store reads zero on the peek port.
- R2: An event that opens a new entry is reported on the commit port exactly 3 cycles after the cycle in which it is presented, with its own row.
- R3: The committed data is the row's stored value OR the merged masks, so earlier bits of the row survive and the event's own mask bits are all set.
- R4: Two events to one row in consecutive cycles produce a single commit carrying the OR of both masks, and the second event produces no commit of its own.
- R5: Two events to one row two cycles apart produce a single commit carrying the OR of both masks.
- R6: An event to a row whose entry commits in the same cycle opens a new entry, and that entry's commit includes the bits just written.
- R7: Disabled stages never match. Four consecutive events to one row give exactly two commits: the OR of the first three, then the OR of all four.
- R8: A cycle with no event produces no commit 3 cycles later and leaves the store unchanged.
- R9: Events to different rows, interleaved with repeats, each commit to their own row in arrival order.
- R10: For any event stream, once the pipeline drains, every row holds the OR of all masks sent to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the pipeline and the store |
| ev_valid | input | 1 | A set event is presented this cycle |
| ev_row | input | ROW_W | Row addressed by the event |
| ev_mask | input | MASK_W | Bits to set in the row |
| cm_valid | output | 1 | The oldest stage writes the store this cycle |
| cm_row | output | ROW_W | Row being written |
| cm_data | output | MASK_W | Value written: merged mask OR stored value |
| pk_row | input | ROW_W | Row to inspect |
| pk_data | output | MASK_W | Current stored value of pk_row |

## Verification
An event presented in cycle t that opens an entry appears on the commit port in cycle t+3. Its value lands in the store at the following edge, so the peek port shows it from cycle t+4. An event merged into an older entry produces no commit of its own; its bits appear in that older entry's commit, in the cycle that entry was already due.

The bench keeps a queue of pending entries, each with its due cycle. In every cycle it compares the commit port with the entry due that cycle, or with "no commit" if none is due. It peeks at the store only after at least four idle cycles, so no entry is still in flight.

// File: rtl/mmp_pkg.sv
package mmp_pkg;

    // Outcome of comparing an incoming event with the in-flight stages.
    typedef enum logic [1:0] {
        MRG_NONE   = 2'd0,
        MRG_NEWEST = 2'd1,
        MRG_MIDDLE = 2'd2
    } merge_e;

    // Stage count; also the read latency of the row store.
    localparam int unsigned STAGES = 3;

endpackage

// File: rtl/mmp_hazard_detect.sv
module mmp_hazard_detect
    import mmp_pkg::*;
#(
    parameter int unsigned ROW_W = 6
) (
    input  logic                          ev_valid,
    input  logic [ROW_W-1:0]              ev_row,
    input  logic [STAGES-1:0]             st_en,
    input  logic [STAGES-1:0][ROW_W-1:0]  st_row,
    output merge_e                        merge,
    output logic                          fold_hit
);

    localparam int unsigned NEWEST = STAGES - 1;
    localparam int unsigned MIDDLE = STAGES - 2;

    logic [STAGES-1:0] hit;

    // Only enabled stages may capture a new event.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_cmp
            assign hit[g] = ev_valid && st_en[g] && (st_row[g] == ev_row);
        end
    endgenerate

    // Newest match wins.
    always_comb begin
        if (hit[NEWEST]) begin
            merge = MRG_NEWEST;
        end else if (hit[MIDDLE]) begin
            merge = MRG_MIDDLE;
        end else begin
            merge = MRG_NONE;
        end
    end

    // A match on the committing stage goes through the read path instead.
    assign fold_hit = hit[0];

endmodule

// File: rtl/mmp_stage_pipe.sv
module mmp_stage_pipe
    import mmp_pkg::*;
#(
    parameter int unsigned ROW_W  = 6,
    parameter int unsigned MASK_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ev_valid,
    input  logic [ROW_W-1:0]              ev_row,
    input  logic [MASK_W-1:0]             ev_mask,
    input  merge_e                        merge,
    output logic [STAGES-1:0]             st_en,
    output logic [STAGES-1:0][ROW_W-1:0]  st_row,
    output logic [STAGES-1:0][MASK_W-1:0] st_mask
);

    localparam int unsigned NEWEST = STAGES - 1;
    localparam int unsigned MIDDLE = STAGES - 2;

    // Rows and enables shift every cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_row <= '0;
            st_en  <= '0;
        end else begin
            st_row[NEWEST] <= ev_row;
            for (int s = 0; s < NEWEST; s++) begin
                st_row[s] <= st_row[s+1];
            end
            for (int s = 0; s < NEWEST; s++) begin
                st_en[s] <= st_en[s+1];
            end
            st_en[NEWEST] <= ev_valid && (merge == MRG_NONE);
        end
    end

    // Masks shift too; a merge ORs the new mask into the matching stage as it moves.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_mask <= '0;
        end else begin
            unique case (merge)
                MRG_NEWEST: begin
                    st_mask[NEWEST] <= '0;
                    st_mask[MIDDLE] <= st_mask[NEWEST] | ev_mask;
                    st_mask[0]      <= st_mask[MIDDLE];
                end
                MRG_MIDDLE: begin
                    st_mask[NEWEST] <= '0;
                    st_mask[MIDDLE] <= st_mask[NEWEST];
                    st_mask[0]      <= st_mask[MIDDLE] | ev_mask;
                end
                default: begin
                    st_mask[NEWEST] <= ev_valid ? ev_mask : '0;
                    st_mask[MIDDLE] <= st_mask[NEWEST];
                    st_mask[0]      <= st_mask[MIDDLE];
                end
            endcase
        end
    end

endmodule

// File: rtl/mmp_row_store.sv
module mmp_row_store #(
    parameter int unsigned ROW_W  = 6,
    parameter int unsigned MASK_W = 8,
    parameter int unsigned LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic              fold_en,
    input  logic [MASK_W-1:0] fold_data,
    output logic [MASK_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [MASK_W-1:0] wr_data,
    input  logic [ROW_W-1:0]  pk_row,
    output logic [MASK_W-1:0] pk_data
);

    localparam int unsigned ROWS = 1 << ROW_W;

    logic [MASK_W-1:0]          cells [ROWS];
    logic [LAT-1:0][MASK_W-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            cells[wr_row] <= wr_data;
        end
    end

    // Read-first at the edge: a write to the same row lands one edge late, so the fold supplies it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q[0] <= rd_en ? (cells[rd_row] | (fold_en ? fold_data : '0)) : '0;
            for (int k = 1; k < LAT; k++) begin
                rd_q[k] <= rd_q[k-1];
            end
        end
    end

    assign rd_data = rd_q[LAT-1];
    assign pk_data = cells[pk_row];

endmodule

// File: rtl/mask_merge_pipe.sv
module mask_merge_pipe
    import mmp_pkg::*;
#(
    parameter int unsigned ROW_W  = 6,
    parameter int unsigned MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [ROW_W-1:0]  ev_row,
    input  logic [MASK_W-1:0] ev_mask,
    output logic              cm_valid,
    output logic [ROW_W-1:0]  cm_row,
    output logic [MASK_W-1:0] cm_data,
    input  logic [ROW_W-1:0]  pk_row,
    output logic [MASK_W-1:0] pk_data
);

    merge_e                        merge;
    logic                          fold_hit;
    logic [STAGES-1:0]             st_en;
    logic [STAGES-1:0][ROW_W-1:0]  st_row;
    logic [STAGES-1:0][MASK_W-1:0] st_mask;
    logic [MASK_W-1:0]             rd_data;

    mmp_hazard_detect #(.ROW_W(ROW_W)) u_detect (
        .ev_valid (ev_valid),
        .ev_row   (ev_row),
        .st_en    (st_en),
        .st_row   (st_row),
        .merge    (merge),
        .fold_hit (fold_hit)
    );

    mmp_stage_pipe #(.ROW_W(ROW_W), .MASK_W(MASK_W)) u_stages (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (ev_valid),
        .ev_row   (ev_row),
        .ev_mask  (ev_mask),
        .merge    (merge),
        .st_en    (st_en),
        .st_row   (st_row),
        .st_mask  (st_mask)
    );

    mmp_row_store #(.ROW_W(ROW_W), .MASK_W(MASK_W), .LAT(STAGES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (ev_valid),
        .rd_row    (ev_row),
        .fold_en   (fold_hit),
        .fold_data (cm_data),
        .rd_data   (rd_data),
        .wr_en     (cm_valid),
        .wr_row    (cm_row),
        .wr_data   (cm_data),
        .pk_row    (pk_row),
        .pk_data   (pk_data)
    );

    // Oldest stage commits its merged mask over the stored value.
    assign cm_valid = st_en[0];
    assign cm_row   = st_row[0];
    assign cm_data  = st_mask[0] | rd_data;

endmodule

// File: rtl/mmp_checker.sv
module mmp_checker #(
    parameter int unsigned ROW_W  = 6,
    parameter int unsigned MASK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic [ROW_W-1:0]  ev_row,
    input logic [MASK_W-1:0] ev_mask,
    input logic              cm_valid,
    input logic [ROW_W-1:0]  cm_row,
    input logic [MASK_W-1:0] cm_data
);

    // Edges since reset, saturating; gates every $past lookback.
    logic [2:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 3'd7) begin
            age <= age + 3'd1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age < 3'd3) |-> !cm_valid);

    p_commit_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd4 && cm_valid) |-> ($past(ev_valid, 3) && $past(ev_row, 3) == cm_row));

    p_commit_keeps_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd4 && cm_valid) |-> ((cm_data & $past(ev_mask, 3)) == $past(ev_mask, 3)));

    p_no_twin_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd4 && cm_valid && $past(cm_valid)) |-> (cm_row != $past(cm_row)));

    p_no_twin_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd4 && cm_valid && $past(cm_valid, 2)) |-> (cm_row != $past(cm_row, 2)));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd4 && !$past(ev_valid, 3)) |-> !cm_valid);

endmodule

bind mask_merge_pipe mmp_checker #(.ROW_W(ROW_W), .MASK_W(MASK_W)) u_mmp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_valid),
    .ev_row   (ev_row),
    .ev_mask  (ev_mask),
    .cm_valid (cm_valid),
    .cm_row   (cm_row),
    .cm_data  (cm_data)
);

// File: tb/mask_merge_pipe_bench.sv
`timescale 1ns/1ps
module mask_merge_pipe_bench;

    localparam int ROW_W  = 4;
    localparam int MASK_W = 8;
    localparam int ROWS   = 1 << ROW_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ev_valid;
    logic [ROW_W-1:0]  ev_row;
    logic [MASK_W-1:0] ev_mask;
    logic              cm_valid;
    logic [ROW_W-1:0]  cm_row;
    logic [MASK_W-1:0] cm_data;
    logic [ROW_W-1:0]  pk_row;
    logic [MASK_W-1:0] pk_data;

    always #2.5 clk = ~clk;

    mask_merge_pipe #(.ROW_W(ROW_W), .MASK_W(MASK_W)) u_mask_merge_pipe (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_row(ev_row), .ev_mask(ev_mask),
        .cm_valid(cm_valid), .cm_row(cm_row), .cm_data(cm_data),
        .pk_row(pk_row), .pk_data(pk_data)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    done  = 0;
    string req   = "R1";

    // Reference: stored rows plus pending entries with their due cycles.
    int ref_mem [ROWS];
    int q_row[$];
    int q_mask[$];
    int q_due[$];

    task automatic chk(input string tag, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // At a falling edge: check this cycle's commit, then present the next event.
    task automatic step(input bit v, input int row, input int mask);
        int  exp_v = 0;
        int  exp_r = 0;
        int  exp_d = 0;
        bit  merged = 0;
        if (q_due.size() > 0 && q_due[0] == cyc) begin
            exp_v = 1;
            exp_r = q_row[0];
            exp_d = ref_mem[exp_r] | q_mask[0];
            ref_mem[exp_r] = exp_d;
            void'(q_row.pop_front());
            void'(q_mask.pop_front());
            void'(q_due.pop_front());
        end
        chk(req, int'(cm_valid), exp_v, "commit valid");
        if (exp_v == 1) begin
            chk(req, int'(cm_row), exp_r, "commit row");
            chk(req, int'(cm_data), exp_d, "commit data");
        end
        if (v) begin
            foreach (q_due[i]) begin
                if (!merged && q_row[i] == row) begin
                    q_mask[i] = q_mask[i] | mask;
                    merged = 1;
                end
            end
            if (!merged) begin
                q_row.push_back(row);
                q_mask.push_back(mask);
                q_due.push_back(cyc + 3);
            end
        end
        ev_valid = v;
        ev_row   = ROW_W'(row);
        ev_mask  = MASK_W'(mask);
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0);
    endtask

    // Compare every stored row with the reference (pipeline must be drained).
    task automatic peek_all(input string tag);
        for (int r = 0; r < ROWS; r++) begin
            pk_row = ROW_W'(r);
            #0.1;
            chk(tag, int'(pk_data), ref_mem[r], "stored row");
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ev_valid = 1'b0; ev_row = '0; ev_mask = '0; pk_row = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet commit port and an all-zero store after reset
        req = "R1";
        peek_all("R1");
        idle(3);

        // R2: lone event commits three cycles later
        req = "R2";
        step(1'b1, 3, 8'h05);
        idle(5);

        // R3: later event keeps the earlier bits
        req = "R3";
        step(1'b1, 3, 8'h30);
        idle(5);
        peek_all("R3");

        // R4: back-to-back pair to one row
        req = "R4";
        step(1'b1, 5, 8'h01);
        step(1'b1, 5, 8'h02);
        idle(5);

        // R5: pair two cycles apart
        req = "R5";
        step(1'b1, 6, 8'h04);
        idle(1);
        step(1'b1, 6, 8'h08);
        idle(5);

        // R6: second event arrives as the first commits
        req = "R6";
        step(1'b1, 7, 8'h10);
        idle(2);
        step(1'b1, 7, 8'h20);
        idle(5);
        peek_all("R6");

        // R7: four in a row: two commits, 0x07 then 0x0F
        req = "R7";
        step(1'b1, 8, 8'h01);
        step(1'b1, 8, 8'h02);
        step(1'b1, 8, 8'h04);
        step(1'b1, 8, 8'h08);
        idle(6);

        // R8: a quiet stretch leaves the store unchanged
        req = "R8";
        idle(8);
        peek_all("R8");

        // R9: interleaved rows with repeats
        req = "R9";
        step(1'b1, 9, 8'h01);
        step(1'b1, 10, 8'h02);
        step(1'b1, 9, 8'h04);
        step(1'b1, 10, 8'h08);
        step(1'b1, 11, 8'h10);
        step(1'b1, 9, 8'h20);
        idle(6);
        peek_all("R9");

        // R10: random streams biased towards a few rows
        req = "R10";
        for (int n = 0; n < 4000; n++) begin
            int row;
            bit v;
            v   = ($urandom_range(0, 9) < 7);
            row = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 2) : $urandom_range(0, ROWS - 1);
            step(v, row, $urandom_range(0, 255));
        end
        idle(6);
        peek_all("R10");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule